// File: doc/BRIEF.md
# Serial Character Transmitter with Line Control

This block turns bytes into asynchronous serial characters. Bytes are pushed into a small transmit queue; a framing engine takes them one at a time and shifts each out on the serial line, advancing by one bit each time the external baud tick pulses. A character is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits.

Static line-control inputs choose the word length, whether parity is sent, and whether it is even, odd or held at a constant value. They also choose the stop-bit count and whether a break is sent. The engine captures these settings when a character starts, so a change made during a character applies to the next one. Three conditions hold a new character back: transmit enable is low, a break is requested, or flow control is on while the clear-to-send input is low. A character that has already started always runs to its end. Full, empty and busy status flags are driven out for the surrounding logic.

Top module: `sertx_top`

## Requirements
- R1: A character is a start bit of 0, then `wlen + 5` data bits (word-length code 0..3 gives 5..8 bits), least significant bit first, each held for one baud-tick interval.
- R2: With `par_en` = 1 and `par_stick` = 0, one parity bit follows the data: with `par_even` = 1 it equals the XOR of the sent data bits, and with `par_even` = 0 it equals the inverse of that XOR. With `par_en` = 0 no parity bit is sent.
- R3: With `par_en` = 1 and `par_stick` = 1, the parity bit is the constant `~par_even`, whatever the data.
- R4: Stop bits are 1. `two_stop` = 1 sends two of them and `two_stop` = 0 sends one. When another byte is already waiting, its start bit follows the last stop bit directly, with no idle bit between them.
- R5: While `brk` = 1 and no character is in progress, `txd` is 0 and no new character starts. A character already in progress when `brk` rises completes normally, and the line goes low after its last stop bit.
- R6: While `tx_en` = 0 no character starts and the idle line stays 1.
- R7: With `cts_flow_en` = 1 and `cts` = 0 no new character starts. A character in progress when `cts` falls completes. With `cts_flow_en` = 0 the value of `cts` has no effect.
- R8: The queue holds `FIFO_DEPTH` bytes and sends them in write order. `fifo_full` is high when it holds `FIFO_DEPTH` bytes, and a write while it is full is dropped. `fifo_empty` is high when it holds none. The two flags are never high together.
- R9: `busy` is high while a character is in progress or the queue holds a byte, and low otherwise.
- R10: After reset `txd` = 1, `fifo_empty` = 1, `fifo_full` = 0 and `busy` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse per bit interval |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 8 | Byte to send |
| tx_en | input | 1 | Allows new characters to start |
| brk | input | 1 | Hold the line low once idle |
| par_en | input | 1 | Append a parity bit |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| par_stick | input | 1 | Parity bit fixed at `~par_even` |
| two_stop | input | 1 | Send two stop bits |
| wlen | input | 2 | Data bits minus five |
| cts_flow_en | input | 1 | Let `cts` gate character starts |
| cts | input | 1 | Clear to send, active high |
| txd | output | 1 | Serial line |
| fifo_full | output | 1 | Queue full |
| fifo_empty | output | 1 | Queue empty |
| busy | output | 1 | Character in progress or queue not empty |

## Verification
The bench builds the block with `FIFO_DEPTH` = 3. A depth that is not a power of two selects the pointer variant that compares against the last slot before wrapping. Three writes fill the queue, so the dropped fourth write and the full flag are quick to reach. Over about twenty characters the pointers pass the wrap point several times. The baud tick pulses every 8 clocks, so the bench samples each bit at the middle of its interval, and it also counts the gap between back-to-back characters.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP1 = 3'd4,
      ST_STOP2 = 3'd5
   } tx_st_e;

   typedef struct packed {
      logic [1:0] wlen;
      logic       par_en;
      logic       par_even;
      logic       par_stick;
      logic       two_stop;
   } line_cfg_t;

   // Parity value for the bits actually sent under cfg.
   function automatic logic par_bit(input logic [7:0] d, input line_cfg_t c);
      logic [7:0] m;
      m = 8'hFF >> (2'd3 - c.wlen);
      if (c.par_stick) return ~c.par_even;
      return c.par_even ? ^(d & m) : ~^(d & m);
   endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         full,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   initial begin
      if (DEPTH < 2) $fatal(1, "sertx_fifo: DEPTH must be at least 2");
      if (W < 1)     $fatal(1, "sertx_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;
   logic          push, pop;

   assign push = wr_en && !full;
   assign pop  = rd_en && !empty;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_cmp
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp_nx;
         if (pop)  rp <= rp_nx;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign rd_data = mem[rp];
   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
   import sertx_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  line_cfg_t cfg,
   input  logic      brk,
   input  logic      tx_en,
   input  logic      cts,
   input  logic      cts_flow_en,
   input  logic      fifo_empty,
   input  logic [7:0] fifo_data,
   output logic      pop,
   output logic      txd,
   output logic      in_frame
);
   tx_st_e    st, st_nx;
   logic [7:0] sh;
   logic [2:0] bit_idx, last_idx;
   line_cfg_t  lcfg;
   logic       pbit, can_go, launch;

   assign can_go   = !fifo_empty && tx_en && !brk && (!cts_flow_en || cts);
   assign last_idx = 3'd4 + {1'b0, lcfg.wlen};

   always_comb begin
      st_nx  = st;
      launch = 1'b0;
      unique case (st)
         ST_IDLE:  if (tick && can_go) launch = 1'b1;
         ST_START: if (tick) st_nx = ST_DATA;
         ST_DATA:  if (tick && bit_idx == last_idx)
                      st_nx = lcfg.par_en ? ST_PAR : ST_STOP1;
         ST_PAR:   if (tick) st_nx = ST_STOP1;
         ST_STOP1: if (tick) begin
                      if (lcfg.two_stop) st_nx = ST_STOP2;
                      else if (can_go)   launch = 1'b1;
                      else               st_nx = ST_IDLE;
                   end
         ST_STOP2: if (tick) begin
                      if (can_go) launch = 1'b1;
                      else        st_nx = ST_IDLE;
                   end
         default:  st_nx = ST_IDLE;
      endcase
      if (launch) st_nx = ST_START;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         sh      <= '0;
         bit_idx <= '0;
         lcfg    <= '0;
         pbit    <= 1'b0;
      end else begin
         st <= st_nx;
         if (launch) begin
            sh      <= fifo_data;
            lcfg    <= cfg;
            pbit    <= par_bit(fifo_data, cfg);
            bit_idx <= '0;
         end else if (st == ST_DATA && tick) begin
            sh      <= sh >> 1;
            bit_idx <= bit_idx + 1'b1;
         end
      end
   end

   always_comb begin
      unique case (st)
         ST_IDLE:  txd = !brk;
         ST_START: txd = 1'b0;
         ST_DATA:  txd = sh[0];
         ST_PAR:   txd = pbit;
         default:  txd = 1'b1;
      endcase
   end

   assign pop      = launch;
   assign in_frame = (st != ST_IDLE);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
   import sertx_pkg::*;
#(
   parameter int FIFO_DEPTH = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       tx_en,
   input  logic       brk,
   input  logic       par_en,
   input  logic       par_even,
   input  logic       par_stick,
   input  logic       two_stop,
   input  logic [1:0] wlen,
   input  logic       cts_flow_en,
   input  logic       cts,
   output logic       txd,
   output logic       fifo_full,
   output logic       fifo_empty,
   output logic       busy
);
   localparam int BYTE_W = 8;

   line_cfg_t        cfg;
   logic             pop, frame_on;
   logic [BYTE_W-1:0] head;

   assign cfg = '{wlen: wlen, par_en: par_en, par_even: par_even,
                  par_stick: par_stick, two_stop: two_stop};

   sertx_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (pop),
      .rd_data (head),
      .full    (fifo_full),
      .empty   (fifo_empty)
   );

   sertx_framer u_frm (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (baud_tick),
      .cfg         (cfg),
      .brk         (brk),
      .tx_en       (tx_en),
      .cts         (cts),
      .cts_flow_en (cts_flow_en),
      .fifo_empty  (fifo_empty),
      .fifo_data   (head),
      .pop         (pop),
      .txd         (txd),
      .in_frame    (frame_on)
   );

   assign busy = frame_on || !fifo_empty;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic brk,
   input logic cts,
   input logic cts_flow_en,
   input logic txd,
   input logic fifo_full,
   input logic fifo_empty,
   input logic busy,
   input logic frame_on
);
   AST_BREAK_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_on && brk) |=> !frame_on); // R5
   AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (txd == !brk)); // R5
   AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_on && !tx_en) |=> !frame_on); // R6
   AST_CTS_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_on && cts_flow_en && !cts) |=> !frame_on); // R7
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_full && fifo_empty)); // R8
   AST_BUSY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      frame_on |-> busy); // R9
   AST_BUSY_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_empty |-> busy); // R9
endmodule

bind sertx_top sertx_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_en       (tx_en),
   .brk         (brk),
   .cts         (cts),
   .cts_flow_en (cts_flow_en),
   .txd         (txd),
   .fifo_full   (fifo_full),
   .fifo_empty  (fifo_empty),
   .busy        (busy),
   .frame_on    (frame_on)
);

// File: tb/sim_sertx_top.sv
module sim_sertx_top;
   localparam int BDIV  = 8;
   localparam int DEPTH = 3;
   localparam int WDOG  = 100000;
   localparam int NV    = 8;
   // {wlen[1:0], par_en, par_even, par_stick, two_stop, data[7:0]}
   localparam logic [13:0] VEC [NV] = '{
      {2'd3, 4'b0000, 8'hA5},
      {2'd3, 4'b1100, 8'h37},
      {2'd3, 4'b1000, 8'h37},
      {2'd0, 4'b1100, 8'hFF},
      {2'd1, 4'b0001, 8'hC3},
      {2'd2, 4'b1110, 8'h7F},
      {2'd2, 4'b1011, 8'h00},
      {2'd3, 4'b1000, 8'h00}
   };

   logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic tx_en = 1'b1, brk = 1'b0, par_en = 1'b0, par_even = 1'b0;
   logic par_stick = 1'b0, two_stop = 1'b0, cts_flow_en = 1'b0, cts = 1'b1;
   logic [1:0] wlen = 2'd3;
   logic txd, fifo_full, fifo_empty, busy;
   int total = 0, bad = 0;

   always #2 clk = ~clk;

   sertx_top #(.FIFO_DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
      .wr_data(wr_data), .tx_en(tx_en), .brk(brk), .par_en(par_en),
      .par_even(par_even), .par_stick(par_stick), .two_stop(two_stop),
      .wlen(wlen), .cts_flow_en(cts_flow_en), .cts(cts), .txd(txd),
      .fifo_full(fifo_full), .fifo_empty(fifo_empty), .busy(busy)
   );

   initial begin
      int c = 0;
      forever begin
         @(negedge clk);
         c = (c == BDIV - 1) ? 0 : c + 1;
         baud_tick = (c == BDIV - 1);
      end
   end

   initial begin
      repeat (WDOG) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: run hung, act=expired exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk); wr_en = 1'b1; wr_data = b;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic set_cfg(input logic [13:0] v);
      {wlen, par_en, par_even, par_stick, two_stop} = v[13:8];
   endtask

   task automatic wait_bits(input int n);
      repeat (n * BDIV) @(negedge clk);
   endtask

   // act: 0 none, 1 drop cts during data, 2 raise brk during data
   task automatic get_frame(input int nd, input logic hp, input logic two, input int act,
                            output logic [7:0] d, output logic p, output logic s0,
                            output logic [1:0] stp, output int waited);
      waited = 0;
      @(negedge clk);
      while (txd !== 1'b0 && waited < 3000) begin
         @(negedge clk); waited++;
      end
      repeat (BDIV / 2) @(negedge clk);
      s0 = txd;
      d  = '0;
      for (int i = 0; i < nd; i++) begin
         repeat (BDIV) @(negedge clk);
         d[i] = txd;
         if (i == 1 && act == 1) cts = 1'b0;
         if (i == 1 && act == 2) brk = 1'b1;
      end
      p = 1'b0;
      if (hp) begin repeat (BDIV) @(negedge clk); p = txd; end
      repeat (BDIV) @(negedge clk);
      stp = {1'b1, txd};
      if (two) begin repeat (BDIV) @(negedge clk); stp[1] = txd; end
   endtask

   initial begin
      logic [7:0] d, m, ed;
      logic p, s0, ep;
      logic [1:0] stp;
      int w;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 txd", txd, 1); chk("R10 empty", fifo_empty, 1);
      chk("R10 full", fifo_full, 0); chk("R10 busy", busy, 0);

      // table walk: R1 R2 R3 R4
      for (int i = 0; i < NV; i++) begin
         logic [13:0] v;
         v = VEC[i];
         set_cfg(v);
         put(v[7:0]);
         get_frame(int'(v[13:12]) + 5, v[11], v[8], 0, d, p, s0, stp, w);
         m  = 8'hFF >> (2'd3 - v[13:12]);
         ed = v[7:0] & m;
         ep = v[9] ? ~v[10] : (v[10] ? ^ed : ~^ed);
         chk("R1 start", s0, 0);
         chk("R1 data", d, ed);
         if (v[11]) chk(v[9] ? "R3 stick parity" : "R2 parity", p, ep);
         chk("R4 stop bits", stp, 2'b11);
         wait_bits(1);
      end
      set_cfg({2'd3, 4'b0000, 8'h00});

      // queue fill with transmit disabled: R6 R8
      tx_en = 1'b0;
      put(8'h11); put(8'h22); put(8'h33); put(8'h44);
      chk("R8 full", fifo_full, 1); chk("R8 empty", fifo_empty, 0);
      chk("R9 busy queued", busy, 1);
      wait_bits(3);
      chk("R6 line idle while disabled", txd, 1);
      tx_en = 1'b1;
      get_frame(8, 0, 0, 0, d, p, s0, stp, w);
      chk("R8 order 1", d, 8'h11);
      get_frame(8, 0, 0, 0, d, p, s0, stp, w);
      chk("R8 order 2", d, 8'h22);
      chk("R4 back-to-back gap", (w <= BDIV / 2), 1);
      get_frame(8, 0, 0, 0, d, p, s0, stp, w);
      chk("R8 order 3", d, 8'h33);
      wait_bits(2);
      chk("R8 dropped write", txd, 1); chk("R8 empty after", fifo_empty, 1);
      chk("R9 busy low", busy, 0);

      // flow control: R7
      cts_flow_en = 1'b1; cts = 1'b0;
      put(8'h5A);
      wait_bits(4);
      chk("R7 held by cts", txd, 1); chk("R9 busy while held", busy, 1);
      cts = 1'b1;
      get_frame(8, 0, 0, 0, d, p, s0, stp, w);
      chk("R7 sends after cts", d, 8'h5A);
      put(8'h96);
      get_frame(8, 0, 0, 1, d, p, s0, stp, w);
      chk("R7 completes after cts drop", d, 8'h96);
      chk("R7 stop after cts drop", stp, 2'b11);
      put(8'h3C);
      wait_bits(3);
      chk("R7 no start after drop", txd, 1);
      cts_flow_en = 1'b0;
      get_frame(8, 0, 0, 0, d, p, s0, stp, w);
      chk("R7 cts ignored when off", d, 8'h3C);
      cts = 1'b1;

      // break: R5
      wait_bits(1);
      brk = 1'b1;
      @(negedge clk);
      chk("R5 idle break low", txd, 0);
      brk = 1'b0;
      put(8'hE1);
      get_frame(8, 0, 0, 2, d, p, s0, stp, w);
      chk("R5 frame completes", d, 8'hE1);
      chk("R5 stop before break", stp, 2'b11);
      wait_bits(1);
      chk("R5 low after frame", txd, 0);
      put(8'h18);
      wait_bits(3);
      chk("R5 no start in break", txd, 0);
      chk("R5 byte waits", fifo_empty, 0);
      brk = 1'b0;
      get_frame(8, 0, 0, 0, d, p, s0, stp, w);
      chk("R5 sends after break", d, 8'h18);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule